// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block is a watchdog timer. It counts ticks from one of several clock enables and raises a one-cycle time-out pulse when the count runs out. Software must restart the count often enough to prevent the pulse. Every tick passes through a fixed base divider of 2^BASE_BITS stages, 256 at the default. A power-of-two prescaler follows it, and its ratio is selected by the low three bits of an 8-bit control register.

The chip's option fuses are modelled as input pins that are held static. They set four things:
- whether the watchdog is enabled,
- which tick source drives it,
- whether the real-time-clock mode is present,
- whether a clear takes one command or two distinct commands.

In two-command mode the count restarts only once both commands have arrived, in either order or in the same cycle. A halt request always restarts the count. The block has no data stream, so it has no valid/ready handshake: every pin is a plain control or status signal, sampled or driven on the rising edge of `clk`.

Top module: `wdt_core`

## Requirements
- R1: While `rst_n` is low and right after it rises, `timeout` is 0 and `reg_rdata` reads 8'h07.
- R2: A write with `reg_we` high stores all 8 bits of `reg_wdata`, and `reg_rdata` shows them from the next cycle. Bits 7:3 are user flags with no effect on timing.
- R3: After a clear, a time-out arrives on exactly the (2^BASE_BITS × 2^ws)-th tick, where ws = `reg_rdata[2:0]`. The count then restarts from zero, so the next time-out follows after the same number of ticks.
- R4: `timeout` is high for exactly one cycle, in the cycle after the clock edge that samples the terminal tick.
- R5: `opt_src` selects the tick source:
  - 0 is `osc_tick`.
  - 1 is `rtc_tick`, used only when `opt_rtc_mode` is 1 and giving no ticks otherwise.
  - 2 is an internal tick every fourth `clk` cycle. Its phase restarts on every clear, so the first time-out comes 4 × 2^BASE_BITS × 2^ws cycles after the clearing edge.
  - 3 gives no ticks.
- R6: With `opt_dual_clr` = 0, a cycle with either bit of `clr_cmd` high restarts the count.
- R7: With `opt_dual_clr` = 1, the count restarts only when both `clr_cmd[0]` and `clr_cmd[1]` have been seen, in any order or together. Repeating one command does not restart it.
- R8: `halt` restarts the count in both clear modes. It also discards a half-received command pair.
- R9: With `opt_wdt_en` = 0:
  - no time-out occurs;
  - clear commands and halt have no effect, and no half-received pair is remembered;
  - the count stays at zero.
- R10: A change of ws takes effect from the next tick and does not restart the count. If the count already meets the new terminal level, the time-out comes at the next base-divider wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| opt_wdt_en | input | 1 | Option: watchdog enabled |
| opt_src | input | 2 | Option: tick source (0 oscillator, 1 RTC, 2 instruction, 3 none) |
| opt_rtc_mode | input | 1 | Option: RTC clock mode present |
| opt_dual_clr | input | 1 | Option: two distinct clear commands required |
| osc_tick | input | 1 | Dedicated oscillator tick enable |
| rtc_tick | input | 1 | Real-time-clock tick enable |
| clr_cmd | input | 2 | Clear commands; bit 0 first, bit 1 second |
| halt | input | 1 | Halt request, restarts the count |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| timeout | output | 1 | One-cycle time-out pulse |

## Verification
The assertions check four properties on every cycle:
- a time-out is never longer than one cycle;
- the block stays silent when it is disabled or has no usable source;
- a halt or a single-mode clear suppresses the next pulse;
- register writes read back.

The exact tick count to each time-out can only be shown by the bench's sweeps. The same holds for the pairing rules of two-command clears, the discarding of a half pair, and the behaviour of a ws change in the middle of a count. For these the bench counts ticks against arithmetic expectations over every ratio.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_OSC   = 2'd0,
    SRC_RTC   = 2'd1,
    SRC_INSTR = 2'd2,
    SRC_NONE  = 2'd3
  } wdt_src_e;

  localparam int unsigned CTRL_W = 8;
  localparam int unsigned SEL_W  = 3;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h07;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_BITS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  wdt_src_e src,
  input  logic     rtc_mode,
  input  logic     osc_tick,
  input  logic     rtc_tick,
  input  logic     restart,
  output logic     tick
);
  logic [DIV_BITS-1:0] phase;

  // instruction-rate divider, restarted with the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!enable || restart) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_comb begin
    unique case (src)
      SRC_OSC:   tick = osc_tick;
      SRC_RTC:   tick = rtc_tick & rtc_mode;
      SRC_INSTR: tick = (phase == '1);
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl #(
  parameter int unsigned NCMD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            dual,
  input  logic [NCMD-1:0] cmd,
  input  logic            halt,
  output logic            clear
);
  logic [NCMD-1:0] pend;
  logic [NCMD-1:0] seen;
  logic            pair_done;
  logic            any_cmd;

  assign seen      = pend | cmd;
  assign pair_done = &seen;
  assign any_cmd   = |cmd;
  assign clear     = enable & (halt | (dual ? pair_done : any_cmd));

  for (genvar i = 0; i < NCMD; i++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
      end else if (!enable || !dual || clear) begin
        pend[i] <= 1'b0;
      end else if (cmd[i]) begin
        pend[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_BITS = 8,
  parameter int unsigned SEL_BITS  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                clear,
  input  logic                tick,
  input  logic [SEL_BITS-1:0] ws,
  output logic                timeout
);
  localparam int unsigned PS_W = (1 << SEL_BITS) - 1;

  logic [BASE_BITS-1:0] base_q;
  logic [PS_W-1:0]      ps_q;
  logic [PS_W:0]        thr;
  logic                 base_wrap;
  logic                 terminal;

  // prescaler terminal level is ratio - 1
  assign thr       = ({{PS_W{1'b0}}, 1'b1} << ws) - 1'b1;
  assign base_wrap = (base_q == '1);
  assign terminal  = base_wrap && ({1'b0, ps_q} >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      ps_q    <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!enable || clear) begin
        base_q <= '0;
        ps_q   <= '0;
      end else if (tick) begin
        if (terminal) begin
          base_q  <= '0;
          ps_q    <= '0;
          timeout <= 1'b1;
        end else if (base_wrap) begin
          base_q <= '0;
          ps_q   <= ps_q + 1'b1;
        end else begin
          base_q <= base_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= CTRL_RESET;
    end else if (we) begin
      q <= wdata;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_BITS = 8,
  parameter int unsigned DIV_BITS  = 2,
  parameter int unsigned NCMD      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_wdt_en,
  input  logic [1:0]        opt_src,
  input  logic              opt_rtc_mode,
  input  logic              opt_dual_clr,
  input  logic              osc_tick,
  input  logic              rtc_tick,
  input  logic [NCMD-1:0]   clr_cmd,
  input  logic              halt,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              timeout
);
  logic clear;
  logic tick;

  wdt_ctrl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .wdata (reg_wdata),
    .q     (reg_rdata)
  );

  wdt_clear_ctl #(.NCMD(NCMD)) u_clr (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (opt_wdt_en),
    .dual   (opt_dual_clr),
    .cmd    (clr_cmd),
    .halt   (halt),
    .clear  (clear)
  );

  wdt_tick_gen #(.DIV_BITS(DIV_BITS)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (opt_wdt_en),
    .src      (wdt_src_e'(opt_src)),
    .rtc_mode (opt_rtc_mode),
    .osc_tick (osc_tick),
    .rtc_tick (rtc_tick),
    .restart  (clear),
    .tick     (tick)
  );

  wdt_counter #(.BASE_BITS(BASE_BITS), .SEL_BITS(SEL_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (opt_wdt_en),
    .clear   (clear),
    .tick    (tick),
    .ws      (reg_rdata[SEL_W-1:0]),
    .timeout (timeout)
  );
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int unsigned NCMD = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            opt_wdt_en,
  input logic [1:0]      opt_src,
  input logic            opt_rtc_mode,
  input logic            opt_dual_clr,
  input logic [NCMD-1:0] clr_cmd,
  input logic            halt,
  input logic            reg_we,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic            timeout
);
  AST_TO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R4

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_wdt_en |=> !timeout); // R9

  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((opt_src == 2'd3) || (opt_src == 2'd1 && !opt_rtc_mode)) |=> !timeout); // R5

  AST_HALT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_wdt_en && halt) |=> !timeout); // R8

  AST_SINGLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_wdt_en && !opt_dual_clr && (clr_cmd != '0)) |=> !timeout); // R6

  AST_REG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_rdata == $past(reg_wdata))); // R2
endmodule

bind wdt_core wdt_core_chk #(.NCMD(NCMD)) u_chk (.*);

// File: tb/tb_wdt_core.sv
`timescale 1ns/1ps
module tb_wdt_core;
  localparam int unsigned BB = 2;
  localparam int unsigned BASE_N = 1 << BB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opt_wdt_en = 1'b1;
  logic [1:0] opt_src = 2'd0;
  logic       opt_rtc_mode = 1'b0;
  logic       opt_dual_clr = 1'b0;
  logic       osc_tick = 1'b0;
  logic       rtc_tick = 1'b0;
  logic [1:0] clr_cmd = 2'b00;
  logic       halt = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       timeout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_core #(.BASE_BITS(BB)) dut (
    .clk(clk), .rst_n(rst_n), .opt_wdt_en(opt_wdt_en), .opt_src(opt_src),
    .opt_rtc_mode(opt_rtc_mode), .opt_dual_clr(opt_dual_clr),
    .osc_tick(osc_tick), .rtc_tick(rtc_tick), .clr_cmd(clr_cmd), .halt(halt),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one tick on source 0 (osc) or 1 (rtc); returns with timeout from that edge visible
  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) osc_tick = 1'b1; else rtc_tick = 1'b1;
    @(negedge clk);
    osc_tick = 1'b0;
    rtc_tick = 1'b0;
  endtask

  task automatic ticks(input int which, input int k);
    for (int i = 0; i < k; i++) pulse(which);
  endtask

  // ticks until a time-out; n = 0 if none within limit; checks pulse width (R4)
  task automatic run_to(input int which, input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      pulse(which);
      if (timeout) begin
        n = i;
        @(negedge clk);
        chk(!timeout, "R4 pulse width", int'(timeout), 0);
        break;
      end
    end
  endtask

  task automatic cmd(input logic [1:0] v);
    @(negedge clk); clr_cmd = v;
    @(negedge clk); clr_cmd = 2'b00;
  endtask

  task automatic do_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    chk(timeout == 1'b0, "R1 timeout in reset", int'(timeout), 0);
    chk(reg_rdata == 8'h07, "R1 rdata in reset", int'(reg_rdata), 8'h07);
    rst_n = 1'b1;
    @(negedge clk);
    chk(timeout == 1'b0 && reg_rdata == 8'h07, "R1 after reset", int'(reg_rdata), 8'h07);

    // R2 readback
    for (int v = 0; v < 256; v += 37) begin
      wr(8'(v));
      chk(reg_rdata == 8'(v), "R2 readback", int'(reg_rdata), v);
    end

    // R3 period sweep over every ws, flags varied (R2 no timing effect)
    for (int ws = 0; ws < 8; ws++) begin
      wr({5'(ws * 7 + 3), 3'(ws)});
      cmd(2'b01);
      run_to(0, 2000, n);
      chk(n == (BASE_N << ws), "R3 first period", n, BASE_N << ws);
      run_to(0, 2000, n);
      chk(n == (BASE_N << ws), "R3 restart period", n, BASE_N << ws);
    end

    // R6 single clear with either command bit
    wr(8'h01);
    cmd(2'b01);
    ticks(0, 5); cmd(2'b01); run_to(0, 100, n);
    chk(n == 8, "R6 clear via bit0", n, 8);
    ticks(0, 5); cmd(2'b10); run_to(0, 100, n);
    chk(n == 8, "R6 clear via bit1", n, 8);

    // R8 halt in single mode
    ticks(0, 6); do_halt(); run_to(0, 100, n);
    chk(n == 8, "R8 halt single mode", n, 8);

    // R7 dual clear
    opt_dual_clr = 1'b1;
    do_halt();
    ticks(0, 5); cmd(2'b01); run_to(0, 100, n);
    chk(n == 3, "R7 one command alone", n, 3);
    do_halt();
    ticks(0, 5); cmd(2'b01); ticks(0, 1); cmd(2'b10); run_to(0, 100, n);
    chk(n == 8, "R7 pair in order", n, 8);
    ticks(0, 5); cmd(2'b10); cmd(2'b01); run_to(0, 100, n);
    chk(n == 8, "R7 pair reversed", n, 8);
    ticks(0, 5); cmd(2'b11); run_to(0, 100, n);
    chk(n == 8, "R7 pair same cycle", n, 8);
    do_halt();
    ticks(0, 5); cmd(2'b01); cmd(2'b01); run_to(0, 100, n);
    chk(n == 3, "R7 repeated command", n, 3);

    // R8 halt discards half pair
    do_halt(); cmd(2'b01); do_halt();
    ticks(0, 5); cmd(2'b10); run_to(0, 100, n);
    chk(n == 3, "R8 halt discards pending", n, 3);
    ticks(0, 6); do_halt(); run_to(0, 100, n);
    chk(n == 8, "R8 halt dual mode", n, 8);

    // R9 disabled
    do_halt();
    opt_wdt_en = 1'b0;
    cmd(2'b01); do_halt();
    run_to(0, 40, n);
    chk(n == 0, "R9 no timeout when disabled", n, 0);
    opt_wdt_en = 1'b1;
    ticks(0, 5); cmd(2'b10); run_to(0, 100, n);
    chk(n == 3, "R9 command ignored while disabled", n, 3);
    opt_wdt_en = 1'b0;
    ticks(0, 3);
    opt_wdt_en = 1'b1;
    run_to(0, 100, n);
    chk(n == 8, "R9 count held at zero", n, 8);
    opt_dual_clr = 1'b0;

    // R10 ws change mid-count
    wr(8'h02); cmd(2'b01);
    ticks(0, 6); wr(8'h01); run_to(0, 100, n);
    chk(n == 2, "R10 ratio lowered", n, 2);
    wr(8'h00); cmd(2'b01);
    ticks(0, 2); wr(8'h03); run_to(0, 100, n);
    chk(n == 30, "R10 ratio raised", n, 30);
    wr(8'h02); cmd(2'b01);
    ticks(0, 13); wr(8'h01); run_to(0, 100, n);
    chk(n == 3, "R10 past new level", n, 3);

    // R5 sources
    wr(8'h00);
    opt_src = 2'd1; opt_rtc_mode = 1'b1;
    cmd(2'b01);
    run_to(0, 20, n);
    chk(n == 0, "R5 osc ignored on rtc source", n, 0);
    cmd(2'b01);
    run_to(1, 20, n);
    chk(n == BASE_N, "R5 rtc source", n, BASE_N);
    opt_rtc_mode = 1'b0;
    cmd(2'b01);
    run_to(1, 20, n);
    chk(n == 0, "R5 rtc without rtc mode", n, 0);
    opt_src = 2'd3;
    cmd(2'b01);
    run_to(0, 10, n); chk(n == 0, "R5 no source osc", n, 0);
    run_to(1, 10, n); chk(n == 0, "R5 no source rtc", n, 0);
    opt_src = 2'd0;
    cmd(2'b01);
    run_to(1, 20, n);
    chk(n == 0, "R5 rtc ignored on osc source", n, 0);

    // R5 instruction tick: cycles from clearing edge
    for (int ws = 0; ws < 3; ws++) begin
      int first;
      int second;
      wr(8'(ws));
      opt_src = 2'd2;
      @(negedge clk); clr_cmd = 2'b01;
      @(negedge clk); clr_cmd = 2'b00;
      first = 0; second = 0;
      for (int k = 1; k <= 200; k++) begin
        @(negedge clk);
        if (timeout) begin
          if (first == 0) first = k;
          else begin second = k; break; end
        end
      end
      chk(first == 4 * (BASE_N << ws), "R5 instruction first", first, 4 * (BASE_N << ws));
      chk(second == 8 * (BASE_N << ws), "R5 instruction second", second, 8 * (BASE_N << ws));
      opt_src = 2'd0;
      cmd(2'b01);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule